// File: doc/BRIEF.md
# CAN Status and Interrupt Identifier

This block is the host-facing status and interrupt source logic of a CAN controller that owns up to 32 message objects. A protocol core feeds it single-cycle strobes for a successful transmission, a successful reception and a completed bus error classification, together with live transmit and receive error counts, a receive-passive flag, a bus-off flag and one interrupt-pending line per message object. The block keeps a status word, a sampled error-count word and a control word, and it presents an interrupt identifier that the host polls to learn what needs service.

The identifier names a pending status event first (value 0x8000). If no status event is pending, it names the lowest-numbered pending message object (1 to 32). If nothing is pending, it reads zero. The host clears a status event by reading the status word. It can load the reserved code 7 into the last-error field and later tell whether any bus event has occurred since. A single interrupt line follows the identifier when the global enable is set.

Register addresses on the 2-bit host address: 0 control, 1 status, 2 error counts, 3 interrupt identifier. Host reads are combinational on the read-data port; every write and every side effect of a read takes hold at the rising clock edge.

Top module: `can_stat_irq`

## Requirements
- R1: After reset, every host register reads 0 and `irq` is low.
- R2: Status bit 3 (transmit OK) and bit 4 (receive OK) are set by `ev_tx_ok` and `ev_rx_ok`. A host write to status with the bit at 0 clears it, and a host write with the bit at 1 leaves it unchanged. When a setting strobe and a clearing write meet in one cycle, the bit ends set.
- R3: Status bits 2:0 hold the last-error code (0 none, 1 stuff, 2 form, 3 ack, 4 bit-1, 5 bit-0, 6 CRC, 7 reserved). `ev_err_valid` loads `ev_err_code`, and a host write to status loads `reg_wdata[2:0]`. When both happen in the same cycle, the hardware code wins.
- R4: A last-error code of 7 written by the host stays 7 until the next `ev_err_valid`, whatever other strobes occur. This includes an event that reports code 0.
- R5: The error-count register (address 2) reads {`rx_passive_in`, `rec_in`[6:0], `tec_in`[7:0]} as sampled at the previous clock edge.
- R6: Status bit 6 (warning) is set when the transmit count or the receive count is at least 96. Status bit 5 (passive) is set when the transmit count exceeds 127 or `rx_passive_in` is high. Status bit 7 follows `bus_off_in`. All three follow their inputs one edge later, and host writes to bits 7:5 have no effect.
- R7: The identifier (address 3) reads 0x8000 while a status event is pending. Otherwise it reads the number of the lowest pending object (object n is `obj_pend_in[n-1]`, sampled one edge earlier). With nothing pending it reads 0.
- R8: When control bit 2 is set, a status event becomes pending on `ev_tx_ok`, on `ev_rx_ok`, or on `ev_err_valid` with a code from 1 to 6. When control bit 2 is clear, none of these causes a status event.
- R9: When control bit 3 is set, a status event becomes pending whenever any of status bits 7:5 changes. When control bit 3 is clear, such changes cause no status event.
- R10: A host read of the status register clears a pending status event, unless a new enabled cause arrives in the same cycle.
- R11: Control bits 3:1 are writable and read back; every other control bit reads 0. `irq` is high exactly when control bit 1 is set and the identifier is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (side effects at the edge) |
| reg_addr | input | 2 | Host register address |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data, combinational on reg_addr |
| ev_tx_ok | input | 1 | Frame transmitted successfully |
| ev_rx_ok | input | 1 | Frame received successfully |
| ev_err_valid | input | 1 | Bus event classified, code on ev_err_code |
| ev_err_code | input | 3 | Last-error code of the event |
| tec_in | input | 8 | Transmit error count |
| rec_in | input | 7 | Receive error count |
| rx_passive_in | input | 1 | Receiver is error passive |
| bus_off_in | input | 1 | Node is bus-off |
| obj_pend_in | input | 32 | Per-object interrupt pending, bit n-1 for object n |
| irq | output | 1 | Interrupt request |

## Verification
Every result takes effect at the first rising edge after its stimulus: strobes, writes, read-clears, counter sampling, status flags and the registered object-pending vector all settle in one edge. `irq` and read data then follow combinationally. The bench therefore drives every stimulus just after a falling edge, lets exactly one rising edge pass, and samples read data and `irq` a few nanoseconds into the following low phase. Register reads used as probes are issued in their own cycle. A probe of the status word therefore lands on the edge after the stimulus, and any read-clear it triggers is accounted for in the next expectation.

// File: rtl/can_si_pkg.sv
package can_si_pkg;

  // Host register map (2-bit address)
  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_STAT  = 2'd1;
  localparam logic [1:0] ADDR_ERRC  = 2'd2;
  localparam logic [1:0] ADDR_INTID = 2'd3;

  // Last-error code values
  localparam logic [2:0] LEC_NONE = 3'd0;
  localparam logic [2:0] LEC_IDLE = 3'd7;

  // Identifier value for a pending status event
  localparam logic [15:0] INTID_STATUS = 16'h8000;

  // Control bit positions
  localparam int CTRL_IE  = 1;
  localparam int CTRL_SIE = 2;
  localparam int CTRL_EIE = 3;

  typedef struct packed {
    logic boff;
    logic ewarn;
    logic epass;
  } bus_state_t;

endpackage

// File: rtl/can_si_errview.sv
module can_si_errview
  import can_si_pkg::*;
#(
  parameter int TEC_W         = 8,
  parameter int REC_W         = 7,
  parameter int WARN_LIMIT    = 96,
  parameter int PASSIVE_LIMIT = 127,
  localparam int ERRC_W       = TEC_W + REC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEC_W-1:0]  tec,
  input  logic [REC_W-1:0]  rec,
  input  logic              rx_passive,
  input  logic              bus_off,
  output logic [ERRC_W-1:0] errc_q,
  output bus_state_t        state_q,
  output logic              state_chg
);

  localparam logic [TEC_W-1:0] TEC_WARN = TEC_W'(WARN_LIMIT);
  localparam logic [REC_W-1:0] REC_WARN = REC_W'(WARN_LIMIT);
  localparam logic [TEC_W-1:0] TEC_PASS = TEC_W'(PASSIVE_LIMIT);

  logic [ERRC_W-1:0] errc_d;
  bus_state_t        state_d;
  logic              errc_en;

  always_comb begin
    errc_d        = {rx_passive, rec, tec};
    errc_en       = (errc_d != errc_q);
    state_d.boff  = bus_off;
    state_d.ewarn = (tec >= TEC_WARN) || (rec >= REC_WARN);
    state_d.epass = (tec > TEC_PASS) || rx_passive;
    state_chg     = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      errc_q  <= '0;
      state_q <= '0;
    end else begin
      if (errc_en)   errc_q  <= errc_d;
      if (state_chg) state_q <= state_d;
    end
  end

endmodule

// File: rtl/can_si_status.sv
module can_si_status
  import can_si_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_tx_ok,
  input  logic       ev_rx_ok,
  input  logic       ev_err_valid,
  input  logic [2:0] ev_err_code,
  input  logic       host_wr,
  input  logic [4:0] host_wdata,
  input  logic       host_rd,
  input  logic       sie,
  input  logic       eie,
  input  bus_state_t state_q,
  input  logic       state_chg,
  output logic [7:0] stat_word,
  output logic       stat_pend
);

  logic       txok_q, txok_d;
  logic       rxok_q, rxok_d;
  logic [2:0] lec_q, lec_d;
  logic       pend_d;
  logic       lec_err;
  logic       sie_cause;
  logic       pend_set;

  always_comb begin
    // transmit/receive OK: host can only clear, strobes set with priority
    txok_d = txok_q;
    rxok_d = rxok_q;
    if (host_wr && !host_wdata[3]) txok_d = 1'b0;
    if (host_wr && !host_wdata[4]) rxok_d = 1'b0;
    if (ev_tx_ok) txok_d = 1'b1;
    if (ev_rx_ok) rxok_d = 1'b1;

    // last-error code: hardware event beats host write
    lec_d = lec_q;
    if (host_wr)      lec_d = host_wdata[2:0];
    if (ev_err_valid) lec_d = ev_err_code;

    lec_err   = ev_err_valid && (ev_err_code != LEC_NONE) && (ev_err_code != LEC_IDLE);
    sie_cause = ev_tx_ok || ev_rx_ok || lec_err;
    pend_set  = (sie && sie_cause) || (eie && state_chg);

    if (pend_set)     pend_d = 1'b1;
    else if (host_rd) pend_d = 1'b0;
    else              pend_d = stat_pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txok_q    <= 1'b0;
      rxok_q    <= 1'b0;
      lec_q     <= '0;
      stat_pend <= 1'b0;
    end else begin
      txok_q    <= txok_d;
      rxok_q    <= rxok_d;
      lec_q     <= lec_d;
      stat_pend <= pend_d;
    end
  end

  assign stat_word = {state_q.boff, state_q.ewarn, state_q.epass, rxok_q, txok_q, lec_q};

endmodule

// File: rtl/can_si_prio.sv
module can_si_prio
  import can_si_pkg::*;
#(
  parameter int NUM_OBJ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OBJ-1:0] obj_pend,
  input  logic               stat_pend,
  output logic [15:0]        intid
);

  logic [NUM_OBJ-1:0] pend_q;
  logic [15:0]        obj_num;
  logic               pend_en;

  assign pend_en = (obj_pend != pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= obj_pend;
  end

  // lowest index wins: scan downward so the last match is the lowest
  always_comb begin
    obj_num = '0;
    for (int i = NUM_OBJ - 1; i >= 0; i--) begin
      if (pend_q[i]) obj_num = 16'(i + 1);
    end
  end

  assign intid = stat_pend ? INTID_STATUS : obj_num;

endmodule

// File: rtl/can_stat_irq.sv
module can_stat_irq
  import can_si_pkg::*;
#(
  parameter int NUM_OBJ       = 32,
  parameter int TEC_W         = 8,
  parameter int REC_W         = 7,
  parameter int WARN_LIMIT    = 96,
  parameter int PASSIVE_LIMIT = 127
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [1:0]         reg_addr,
  input  logic [15:0]        reg_wdata,
  output logic [15:0]        reg_rdata,
  input  logic               ev_tx_ok,
  input  logic               ev_rx_ok,
  input  logic               ev_err_valid,
  input  logic [2:0]         ev_err_code,
  input  logic [TEC_W-1:0]   tec_in,
  input  logic [REC_W-1:0]   rec_in,
  input  logic               rx_passive_in,
  input  logic               bus_off_in,
  input  logic [NUM_OBJ-1:0] obj_pend_in,
  output logic               irq
);

  localparam int ERRC_W = TEC_W + REC_W + 1;

  logic [3:1]        ctrl_q, ctrl_d;
  logic              ctrl_en;
  logic              ctrl_ie;
  logic              stat_wr, stat_rd;
  logic [7:0]        status_word;
  logic              stat_pend;
  logic [15:0]       intid;
  logic [ERRC_W-1:0] errc_q;
  bus_state_t        state_q;
  logic              state_chg;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata[15:5];

  // control register
  assign ctrl_en = reg_wr && (reg_addr == ADDR_CTRL);
  assign ctrl_d  = reg_wdata[3:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  assign ctrl_ie = ctrl_q[CTRL_IE];
  assign stat_wr = reg_wr && (reg_addr == ADDR_STAT);
  assign stat_rd = reg_rd && (reg_addr == ADDR_STAT);

  can_si_errview #(
    .TEC_W         (TEC_W),
    .REC_W         (REC_W),
    .WARN_LIMIT    (WARN_LIMIT),
    .PASSIVE_LIMIT (PASSIVE_LIMIT)
  ) u_errview (
    .clk        (clk),
    .rst_n      (rst_n),
    .tec        (tec_in),
    .rec        (rec_in),
    .rx_passive (rx_passive_in),
    .bus_off    (bus_off_in),
    .errc_q     (errc_q),
    .state_q    (state_q),
    .state_chg  (state_chg)
  );

  can_si_status u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_tx_ok     (ev_tx_ok),
    .ev_rx_ok     (ev_rx_ok),
    .ev_err_valid (ev_err_valid),
    .ev_err_code  (ev_err_code),
    .host_wr      (stat_wr),
    .host_wdata   (reg_wdata[4:0]),
    .host_rd      (stat_rd),
    .sie          (ctrl_q[CTRL_SIE]),
    .eie          (ctrl_q[CTRL_EIE]),
    .state_q      (state_q),
    .state_chg    (state_chg),
    .stat_word    (status_word),
    .stat_pend    (stat_pend)
  );

  can_si_prio #(
    .NUM_OBJ (NUM_OBJ)
  ) u_prio (
    .clk       (clk),
    .rst_n     (rst_n),
    .obj_pend  (obj_pend_in),
    .stat_pend (stat_pend),
    .intid     (intid)
  );

  always_comb begin
    unique case (reg_addr)
      ADDR_CTRL:  reg_rdata = {12'h000, ctrl_q, 1'b0};
      ADDR_STAT:  reg_rdata = {8'h00, status_word};
      ADDR_ERRC:  reg_rdata = 16'(errc_q);
      default:    reg_rdata = intid;
    endcase
  end

  assign irq = ctrl_ie && (intid != 16'h0000);

endmodule

// File: rtl/can_stat_irq_chk.sv
module can_stat_irq_chk
  import can_si_pkg::*;
#(
  parameter int NUM_OBJ = 32,
  parameter int TEC_W   = 8,
  parameter int REC_W   = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [1:0]       reg_addr,
  input logic [15:0]      reg_wdata,
  input logic             ev_tx_ok,
  input logic             ev_rx_ok,
  input logic             ev_err_valid,
  input logic [TEC_W-1:0] tec_in,
  input logic [REC_W-1:0] rec_in,
  input logic             rx_passive_in,
  input logic             bus_off_in,
  input logic             irq,
  input logic [7:0]       status_word,
  input logic [15:0]      intid,
  input logic             ctrl_ie
);

  // R2: transmit OK is sticky unless the host writes a zero to it
  a_r2_txok_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[3] && !(reg_wr && reg_addr == ADDR_STAT && !reg_wdata[3]))
      |=> status_word[3]);

  // R4: reserved code holds until a new bus event or host write
  a_r4_idle_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[2:0] == LEC_IDLE && !ev_err_valid &&
     !(reg_wr && reg_addr == ADDR_STAT))
      |=> status_word[2:0] == LEC_IDLE);

  // R7: status identifier is exactly 0x8000
  a_r7_status_word_exact: assert property (@(posedge clk) disable iff (!rst_n)
    intid[15] |-> intid[14:0] == 15'd0);

  // R7: object identifiers stay within the object range
  a_r7_object_range: assert property (@(posedge clk) disable iff (!rst_n)
    !intid[15] |-> intid <= 16'(NUM_OBJ));

  // R10: a status read with no new cause clears the status event
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_STAT && !ev_tx_ok && !ev_rx_ok && !ev_err_valid &&
     $stable(tec_in) && $stable(rec_in) && $stable(rx_passive_in) && $stable(bus_off_in))
      |=> !intid[15]);

  // R11: no interrupt without the global enable
  a_r11_gated_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_ie |-> !irq);

endmodule

bind can_stat_irq can_stat_irq_chk #(
  .NUM_OBJ (NUM_OBJ),
  .TEC_W   (TEC_W),
  .REC_W   (REC_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_wr        (reg_wr),
  .reg_rd        (reg_rd),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .ev_tx_ok      (ev_tx_ok),
  .ev_rx_ok      (ev_rx_ok),
  .ev_err_valid  (ev_err_valid),
  .tec_in        (tec_in),
  .rec_in        (rec_in),
  .rx_passive_in (rx_passive_in),
  .bus_off_in    (bus_off_in),
  .irq           (irq),
  .status_word   (status_word),
  .intid         (intid),
  .ctrl_ie       (ctrl_ie)
);

// File: tb/tb_can_stat_irq.sv
`timescale 1ns/1ps
module tb_can_stat_irq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        ev_tx_ok, ev_rx_ok, ev_err_valid;
  logic [2:0]  ev_err_code;
  logic [7:0]  tec_in;
  logic [6:0]  rec_in;
  logic        rx_passive_in, bus_off_in;
  logic [31:0] obj_pend_in;
  logic        irq;

  int nvec = 0;
  int nerr = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  can_stat_irq dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  // read with side effect; returns value seen before the edge
  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #2 d = reg_rdata;
    tick();
    reg_rd = 1'b0;
  endtask

  task automatic pulse_tx();
    ev_tx_ok = 1'b1; tick(); ev_tx_ok = 1'b0;
  endtask

  task automatic pulse_err(input logic [2:0] c);
    ev_err_valid = 1'b1; ev_err_code = c; tick(); ev_err_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      nvec++; nerr++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [31:0] m;
    logic [15:0] e;
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    ev_tx_ok = 0; ev_rx_ok = 0; ev_err_valid = 0; ev_err_code = 0;
    tec_in = 0; rec_in = 0; rx_passive_in = 0; bus_off_in = 0; obj_pend_in = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reset read", {16'h0, d}, 32'h0);
    end
    chk("R1 reset irq", {31'h0, irq}, 32'h0);

    // R11 control readback sweep
    for (int v = 0; v < 16; v++) begin
      wr(2'd0, 16'(v) | 16'hFFF0);
      rd(2'd0, d);
      chk("R11 ctrl readback", {16'h0, d}, 32'(v & 14));
    end
    wr(2'd0, 16'h0);

    // R5/R6 error count and state sweep
    for (int t = 0; t < 256; t++) begin
      tec_in = 8'(t);
      rec_in = 7'((t * 37) % 128);
      rx_passive_in = (t % 5 == 0);
      bus_off_in = (t % 7 == 3);
      tick();
      rd(2'd2, d);
      chk("R5 error count word", {16'h0, d}, {16'h0, rx_passive_in, rec_in, tec_in});
      rd(2'd1, d);
      e = {13'h0, bus_off_in,
           (tec_in >= 8'd96) || (rec_in >= 7'd96),
           (tec_in > 8'd127) || rx_passive_in};
      chk("R6 state flags", {16'h0, 13'h0, d[7:5]}, {16'h0, e});
    end
    tec_in = 0; rec_in = 0; rx_passive_in = 0; bus_off_in = 0;
    tick();
    wr(2'd1, 16'h00E0);
    rd(2'd1, d);
    chk("R6 host write to flags ignored", {16'h0, d}, 32'h0);

    // R3 last-error code
    for (int c = 0; c < 8; c++) begin
      pulse_err(3'(c));
      rd(2'd1, d);
      chk("R3 lec load", {29'h0, d[2:0]}, 32'(c));
    end
    wr(2'd1, 16'h0003);
    rd(2'd1, d);
    chk("R3 host lec write", {29'h0, d[2:0]}, 32'd3);
    reg_wr = 1; reg_addr = 2'd1; reg_wdata = 16'h0005;
    ev_err_valid = 1; ev_err_code = 3'd2;
    tick();
    reg_wr = 0; ev_err_valid = 0;
    rd(2'd1, d);
    chk("R3 hardware beats host", {29'h0, d[2:0]}, 32'd2);

    // R4 reserved code held
    wr(2'd1, 16'h0007);
    repeat (5) tick();
    rd(2'd1, d);
    chk("R4 idle code held", {29'h0, d[2:0]}, 32'd7);
    pulse_tx();
    rd(2'd1, d);
    chk("R4 idle code after tx ok", {29'h0, d[2:0]}, 32'd7);
    pulse_err(3'd0);
    rd(2'd1, d);
    chk("R4 idle code replaced by 0", {29'h0, d[2:0]}, 32'd0);

    // R2 sticky OK bits
    wr(2'd1, 16'h0000);
    pulse_tx();
    rd(2'd1, d);
    chk("R2 txok set", {30'h0, d[4:3]}, 32'b01);
    ev_rx_ok = 1; tick(); ev_rx_ok = 0;
    rd(2'd1, d);
    chk("R2 rxok set", {30'h0, d[4:3]}, 32'b11);
    wr(2'd1, 16'h0018);
    rd(2'd1, d);
    chk("R2 write ones keeps", {30'h0, d[4:3]}, 32'b11);
    wr(2'd1, 16'h0010);
    rd(2'd1, d);
    chk("R2 write zero clears txok", {30'h0, d[4:3]}, 32'b10);
    reg_wr = 1; reg_addr = 2'd1; reg_wdata = 16'h0000; ev_tx_ok = 1;
    tick();
    reg_wr = 0; ev_tx_ok = 0;
    rd(2'd1, d);
    chk("R2 set beats clear", {30'h0, d[4:3]}, 32'b01);

    // R7 identifier sweeps
    for (int i = 0; i < 32; i++) begin
      obj_pend_in = 32'h1 << i;
      tick();
      rd(2'd3, d);
      chk("R7 single object", {16'h0, d}, 32'(i + 1));
    end
    for (int i = 0; i < 64; i++) begin
      m = (32'hFFFF_FFFF << (i % 32)) & ((32'(i) * 32'h9E37_79B9) | 32'h8000_0000);
      if (i >= 32) m = m & 32'h0000_FFFF;
      obj_pend_in = m;
      e = 16'h0;
      for (int b = 31; b >= 0; b--) if (m[b]) e = 16'(b + 1);
      tick();
      rd(2'd3, d);
      chk("R7 lowest of many", {16'h0, d}, {16'h0, e});
    end
    obj_pend_in = 0;
    tick();
    rd(2'd3, d);
    chk("R7 nothing pending", {16'h0, d}, 32'h0);

    // R11 irq gating
    wr(2'd0, 16'h0002);
    obj_pend_in = 32'h10; tick();
    chk("R11 irq with object", {31'h0, irq}, 32'h1);
    obj_pend_in = 0; tick();
    chk("R11 irq idle", {31'h0, irq}, 32'h0);
    wr(2'd0, 16'h0000);
    obj_pend_in = 32'h10; tick();
    chk("R11 irq disabled", {31'h0, irq}, 32'h0);

    // R8 status event gating
    obj_pend_in = 32'h200;
    wr(2'd0, 16'h0006);
    pulse_tx();
    rd(2'd3, d);
    chk("R8 status event priority", {16'h0, d}, 32'h8000);
    chk("R8 irq on status", {31'h0, irq}, 32'h1);
    rd(2'd1, d);
    rd(2'd3, d);
    chk("R10 read cleared status", {16'h0, d}, 32'd10);
    wr(2'd0, 16'h0002);
    ev_rx_ok = 1; tick(); ev_rx_ok = 0;
    rd(2'd3, d);
    chk("R8 no event when disabled", {16'h0, d}, 32'd10);
    wr(2'd0, 16'h0006);
    pulse_err(3'd7);
    rd(2'd3, d);
    chk("R8 code 7 no event", {16'h0, d}, 32'd10);
    pulse_err(3'd0);
    rd(2'd3, d);
    chk("R8 code 0 no event", {16'h0, d}, 32'd10);
    pulse_err(3'd4);
    rd(2'd3, d);
    chk("R8 error code event", {16'h0, d}, 32'h8000);
    rd(2'd1, d);

    // R9 state change gating
    wr(2'd0, 16'h000A);
    tec_in = 8'd100; tick();
    rd(2'd3, d);
    chk("R9 warning change event", {16'h0, d}, 32'h8000);
    rd(2'd1, d);
    rd(2'd3, d);
    chk("R9 cleared", {16'h0, d}, 32'd10);
    wr(2'd0, 16'h0002);
    tec_in = 8'd0; tick();
    rd(2'd3, d);
    chk("R9 no event when disabled", {16'h0, d}, 32'd10);

    // R10 new cause during clearing read
    wr(2'd0, 16'h0006);
    pulse_tx();
    reg_rd = 1; reg_addr = 2'd1; ev_tx_ok = 1;
    tick();
    reg_rd = 0; ev_tx_ok = 0;
    rd(2'd3, d);
    chk("R10 new cause survives read", {16'h0, d}, 32'h8000);
    rd(2'd1, d);
    rd(2'd3, d);
    chk("R10 plain read clears", {16'h0, d}, 32'd10);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule